// File: doc/BRIEF.md
# Tiny 16-bit Load/Store Processor Core

This block is a compact 16-bit processor core for small control tasks. It holds sixteen general-purpose 16-bit registers and runs a sixteen-opcode load/store instruction set. Every instruction is one 16-bit word. Instruction fetches and data accesses share one word-addressed memory port with a request/ready handshake. The core has no interrupt input, so software talks to the outside world by polling memory-mapped words.

The core is a small multi-cycle sequencer. It fetches a word at the program counter, then executes it in the following cycle. Loads and stores take one further memory phase. Any memory phase waits for as long as the memory keeps ready low. Branch and jump targets are absolute 8-bit word addresses, zero-extended to 16 bits. The four shifts act in place on the destination register. The shift amount is a 4-bit immediate.

Top module: `tcore_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the core requests a read (`mem_req`=1, `mem_we`=0) at address 0. All registers read as zero after reset.
- R2: The opcode sits in bits [15:12], with add=0, sub=1, xor=2, and=3, or=4, addi=5, lw=6, sw=7, ldhi=8, bz=9, bnz=10, jal=11, jalr=12, shl=13, shr=14, shra=15. The destination register rd is in [11:8], rs1 in [7:4] and rs2 in [3:0]. imm8 is in [7:0] and imm4 in [7:4]. Bits [3:0] have no effect on lw, sw, jalr and the shifts.
- R3: add, sub, xor, and and or write rs1 op rs2 into rd. Results wrap modulo 2^16.
- R4: addi adds its zero-extended imm8 to rd in place, wrapping modulo 2^16.
- R5: ldhi writes imm8 into rd[15:8] and leaves rd[7:0] unchanged.
- R6: lw reads the word at the address held in rs1 into rd. sw writes rd to the address held in rs1. Write enable is high only in the data phase of sw. lw with rd equal to rs1 uses the old rs1 as its address.
- R7: bz jumps to the zero-extended imm8 when rd is zero. bnz jumps there when rd is nonzero. Otherwise execution continues at PC+1.
- R8: jal jumps to the zero-extended imm8, and jalr jumps to the value of rs1. Both write PC+1 of the jump into rd. jalr with rd equal to rs1 jumps to the old rs1 value.
- R9: shl, shr and shra shift rd in place by imm4 (0 to 15). shr fills with zeros and shra copies the sign bit.
- R10: While `mem_req` is high and `mem_ready` is low, the core holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` unchanged and makes no architectural change.
- R11: Every instruction that is not a branch or jump continues at PC+1. r0 is an ordinary register that can be written and read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_req | output | 1 | Memory access request |
| mem_addr | output | 16 | Word address of the access |
| mem_we | output | 1 | High for a write access |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Read data, valid when `mem_ready` is high |
| mem_ready | input | 1 | Access completes in a cycle where request and ready are both high |

## Verification
The assertions assume that memory never completes an access the core did not request. They also assume that `mem_rdata` is valid in the cycle that ready is high. The bench memory raises ready only while a request is pending and returns the stored word for the current address at once. Programs keep every code and data address below 256. Any access above that is counted as an error, which exposes a sign-extended jump target. One scenario adds three wait cycles to every access. This checks that the outputs stay unchanged during the stall and that the results match the run without waits.

// File: rtl/tcore_pkg.sv
package tcore_pkg;

    localparam int WORD_W    = 16;
    localparam int REG_IDX_W = 4;
    localparam int NUM_REGS  = 1 << REG_IDX_W;
    localparam int IMM8_W    = 8;
    localparam int SHAMT_W   = 4;

    typedef logic [WORD_W-1:0]    word_t;
    typedef logic [REG_IDX_W-1:0] reg_idx_t;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_XOR  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_ADDI = 4'd5,
        OP_LW   = 4'd6,
        OP_SW   = 4'd7,
        OP_LDHI = 4'd8,
        OP_BZ   = 4'd9,
        OP_BNZ  = 4'd10,
        OP_JAL  = 4'd11,
        OP_JALR = 4'd12,
        OP_SHL  = 4'd13,
        OP_SHR  = 4'd14,
        OP_SHRA = 4'd15
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_MEM   = 2'd2
    } state_e;

    typedef struct packed {
        opcode_e              op;
        reg_idx_t             rd;
        reg_idx_t             rs1;
        reg_idx_t             rs2;
        logic [IMM8_W-1:0]    imm8;
        logic [SHAMT_W-1:0]   shamt;
        logic                 reg_write;
        logic                 is_mem;
        logic                 is_store;
        logic                 is_branch;
        logic                 br_on_zero;
        logic                 is_jump;
        logic                 jump_reg;
    } decoded_t;

    function automatic word_t zext8(input logic [IMM8_W-1:0] v);
        return {{(WORD_W-IMM8_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/tcore_decode.sv
module tcore_decode
    import tcore_pkg::*;
(
    input  word_t    instr,
    output decoded_t dec
);

    always_comb begin
        dec            = '0;
        dec.op         = opcode_e'(instr[15:12]);
        dec.rd         = instr[11:8];
        dec.rs1        = instr[7:4];
        dec.rs2        = instr[3:0];
        dec.imm8       = instr[7:0];
        dec.shamt      = instr[7:4];
        case (dec.op)
            OP_ADD, OP_SUB, OP_XOR, OP_AND, OP_OR,
            OP_ADDI, OP_LDHI, OP_SHL, OP_SHR, OP_SHRA: begin
                dec.reg_write = 1'b1;
            end
            OP_LW: begin
                dec.is_mem = 1'b1;
            end
            OP_SW: begin
                dec.is_mem   = 1'b1;
                dec.is_store = 1'b1;
            end
            OP_BZ: begin
                dec.is_branch  = 1'b1;
                dec.br_on_zero = 1'b1;
            end
            OP_BNZ: begin
                dec.is_branch = 1'b1;
            end
            OP_JAL: begin
                dec.reg_write = 1'b1;
                dec.is_jump   = 1'b1;
            end
            OP_JALR: begin
                dec.reg_write = 1'b1;
                dec.is_jump   = 1'b1;
                dec.jump_reg  = 1'b1;
            end
            default: begin
                dec.reg_write = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tcore_regfile.sv
module tcore_regfile
    import tcore_pkg::*;
#(
    parameter int ENTRIES = NUM_REGS,
    parameter int WIDTH   = WORD_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    input  logic [IDX_W-1:0] rd_idx_c,
    output logic [WIDTH-1:0] rd_data_a,
    output logic [WIDTH-1:0] rd_data_b,
    output logic [WIDTH-1:0] rd_data_c
);

    logic [WIDTH-1:0] regs [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                regs[g] <= wr_data;
            end
        end
    end

    assign rd_data_a = regs[rd_idx_a];
    assign rd_data_b = regs[rd_idx_b];
    assign rd_data_c = regs[rd_idx_c];

endmodule

// File: rtl/tcore_alu.sv
module tcore_alu
    import tcore_pkg::*;
(
    input  opcode_e             op,
    input  word_t               src_a,
    input  word_t               src_b,
    input  word_t               dst_val,
    input  logic [IMM8_W-1:0]   imm8,
    input  logic [SHAMT_W-1:0]  shamt,
    input  word_t               link_addr,
    output word_t               result
);

    always_comb begin
        case (op)
            OP_ADD:  result = src_a + src_b;
            OP_SUB:  result = src_a - src_b;
            OP_XOR:  result = src_a ^ src_b;
            OP_AND:  result = src_a & src_b;
            OP_OR:   result = src_a | src_b;
            OP_ADDI: result = dst_val + zext8(imm8);
            OP_LDHI: result = {imm8, dst_val[WORD_W-IMM8_W-1:0]};
            OP_SHL:  result = dst_val << shamt;
            OP_SHR:  result = dst_val >> shamt;
            OP_SHRA: result = word_t'($signed(dst_val) >>> shamt);
            OP_JAL,
            OP_JALR: result = link_addr;
            default: result = dst_val;
        endcase
    end

endmodule

// File: rtl/tcore_top.sv
module tcore_top
    import tcore_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready
);

    state_e   state_q;
    word_t    pc_q;
    word_t    ir_q;
    decoded_t dec;

    word_t    rs1_val;
    word_t    rs2_val;
    word_t    rd_val;
    word_t    alu_out;
    word_t    pc_inc;
    word_t    pc_target;
    logic     rf_we;
    word_t    rf_wdata;
    logic     handshake;
    logic     br_taken;

    tcore_decode u_decode (
        .instr (ir_q),
        .dec   (dec)
    );

    tcore_regfile #(
        .ENTRIES (NUM_REGS),
        .WIDTH   (WORD_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (rf_we),
        .wr_idx    (dec.rd),
        .wr_data   (rf_wdata),
        .rd_idx_a  (dec.rs1),
        .rd_idx_b  (dec.rs2),
        .rd_idx_c  (dec.rd),
        .rd_data_a (rs1_val),
        .rd_data_b (rs2_val),
        .rd_data_c (rd_val)
    );

    assign pc_inc = pc_q + WORD_W'(1);

    tcore_alu u_alu (
        .op        (dec.op),
        .src_a     (rs1_val),
        .src_b     (rs2_val),
        .dst_val   (rd_val),
        .imm8      (dec.imm8),
        .shamt     (dec.shamt),
        .link_addr (pc_inc),
        .result    (alu_out)
    );

    // Memory port: fetch from PC, data phase uses rs1 as the address.
    always_comb begin
        mem_req   = 1'b0;
        mem_addr  = pc_q;
        mem_we    = 1'b0;
        mem_wdata = '0;
        case (state_q)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = pc_q;
            end
            ST_MEM: begin
                mem_req   = 1'b1;
                mem_addr  = rs1_val;
                mem_we    = dec.is_store;
                mem_wdata = rd_val;
            end
            default: begin
                mem_req = 1'b0;
            end
        endcase
    end

    assign handshake = mem_req && mem_ready;

    // Register write-back: ALU result in execute, load data in the memory phase.
    always_comb begin
        rf_we    = 1'b0;
        rf_wdata = alu_out;
        if (state_q == ST_EXEC && dec.reg_write) begin
            rf_we = 1'b1;
        end else if (state_q == ST_MEM && handshake && !dec.is_store) begin
            rf_we    = 1'b1;
            rf_wdata = mem_rdata;
        end
    end

    // Next-PC selection for the execute cycle.
    assign br_taken = dec.is_branch && ((rd_val == '0) == dec.br_on_zero);

    always_comb begin
        pc_target = pc_inc;
        if (dec.is_jump) begin
            pc_target = dec.jump_reg ? rs1_val : zext8(dec.imm8);
        end else if (br_taken) begin
            pc_target = zext8(dec.imm8);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
            pc_q    <= '0;
            ir_q    <= '0;
        end else begin
            case (state_q)
                ST_FETCH: begin
                    if (handshake) begin
                        ir_q    <= mem_rdata;
                        state_q <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    if (dec.is_mem) begin
                        state_q <= ST_MEM;
                    end else begin
                        pc_q    <= pc_target;
                        state_q <= ST_FETCH;
                    end
                end
                ST_MEM: begin
                    if (handshake) begin
                        pc_q    <= pc_inc;
                        state_q <= ST_FETCH;
                    end
                end
                default: begin
                    state_q <= ST_FETCH;
                end
            endcase
        end
    end

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------

    // R10: a stalled access keeps every request output unchanged.
    a_r10_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R1: the first cycle after reset is a read request at address 0.
    a_r1_first_fetch: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mem_req && !mem_we && (mem_addr == '0)));

    // R6: a completed store is followed by a fetch of the next word.
    a_r6_store_then_fetch: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_ready) |=>
            (mem_req && !mem_we && (mem_addr == $past(pc_q) + WORD_W'(1))));

    // R7: a taken branch lands on the zero-extended immediate.
    a_r7_branch_target: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC && dec.is_branch && ((rd_val == '0) == dec.br_on_zero)) |=>
            (pc_q == zext8($past(dec.imm8))));

    // R8: a register jump lands on the old value of rs1.
    a_r8_jump_reg_target: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC && dec.jump_reg) |=> (pc_q == $past(rs1_val)));

    // R11: straight-line instructions advance the PC by one.
    a_r11_seq_pc: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC && !dec.is_branch && !dec.is_jump && !dec.is_mem) |=>
            (pc_q == $past(pc_q) + WORD_W'(1)));

endmodule

// File: tb/tcore_top_tb.sv
module tcore_top_tb;

    localparam logic [3:0] K_ADD = 4'd0, K_SUB = 4'd1, K_XOR = 4'd2, K_AND = 4'd3,
                           K_OR = 4'd4, K_ADDI = 4'd5, K_LW = 4'd6, K_SW = 4'd7,
                           K_LDHI = 4'd8, K_BZ = 4'd9, K_BNZ = 4'd10, K_JAL = 4'd11,
                           K_JALR = 4'd12, K_SHL = 4'd13, K_SHR = 4'd14, K_SHRA = 4'd15;
    localparam int RUN_CYCLES = 1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_ready;

    logic [15:0] img [256];
    logic [15:0] mem [256];
    int          stall_len = 0;
    int          wait_cnt  = 0;
    int          oor_hits  = 0;
    int          hold_errs = 0;
    int          n_checks  = 0;
    int          n_fail    = 0;
    int          wp        = 0;
    logic        prev_wait = 1'b0;
    logic [15:0] prev_addr, prev_wdata;
    logic        prev_we;

    always #4 clk = ~clk;

    tcore_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready)
    );

    // Behavioural memory with a programmable number of wait cycles.
    assign mem_ready = mem_req && (wait_cnt >= stall_len);
    assign mem_rdata = (mem_addr[15:8] == 8'h00) ? mem[mem_addr[7:0]] : 16'h0000;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] = img[i];
            wait_cnt  <= 0;
            prev_wait <= 1'b0;
        end else begin
            if (mem_req && mem_ready) begin
                if (mem_addr[15:8] != 8'h00) oor_hits <= oor_hits + 1;
                else if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
            end
            wait_cnt <= (mem_req && !mem_ready) ? wait_cnt + 1 : 0;
            if (prev_wait && (!mem_req || mem_addr != prev_addr ||
                              mem_we != prev_we || mem_wdata != prev_wdata))
                hold_errs <= hold_errs + 1;
            prev_wait  <= mem_req && !mem_ready;
            prev_addr  <= mem_addr;
            prev_we    <= mem_we;
            prev_wdata <= mem_wdata;
        end
    end

    function automatic logic [15:0] enc(input logic [3:0] op, input logic [3:0] rd,
                                        input logic [7:0] lo);
        return {op, rd, lo};
    endfunction

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic put(input logic [15:0] w);
        img[wp] = w;
        wp++;
    endtask

    task automatic put_at(input int a, input logic [15:0] w);
        img[a] = w;
    endtask

    task automatic halt_here();
        put(enc(K_JAL, 4'd13, wp[7:0]));
    endtask

    task automatic prep(input int stall);
        @(negedge clk);
        rst       = 1'b1;
        stall_len = stall;
        oor_hits  = 0;
        hold_errs = 0;
        wp        = 0;
        for (int i = 0; i < 256; i++) img[i] = 16'h0000;
    endtask

    task automatic run();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (RUN_CYCLES) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------

    task automatic t_reset();
        prep(0);
        put(enc(K_ADDI, 4'd14, 8'h80));
        put(enc(K_SW, 4'd9, 8'hE0));
        halt_here();
        repeat (3) @(negedge clk);
        chk("R1 req in reset", {15'd0, mem_req}, 16'd1);
        chk("R1 we in reset", {15'd0, mem_we}, 16'd0);
        chk("R1 addr in reset", mem_addr, 16'h0000);
        rst = 1'b0;
        #1;
        chk("R1 addr after release", mem_addr, 16'h0000);
        repeat (RUN_CYCLES) @(negedge clk);
        img[16'h80] = 16'hFFFF;
        chk("R1 reg reads zero", mem[8'h80], 16'h0000);
    endtask

    task automatic alu_program();
        put(enc(K_LDHI, 4'd1, 8'h12));
        put(enc(K_ADDI, 4'd1, 8'h34));
        put(enc(K_LDHI, 4'd2, 8'hF0));
        put(enc(K_ADDI, 4'd2, 8'h0F));
        put(enc(K_ADDI, 4'd14, 8'h80));
        for (int k = 0; k < 5; k++) begin
            put(enc(4'(k), 4'(3 + k), 8'h12));
            put(enc(K_SW, 4'(3 + k), 8'hE0));
            put(enc(K_ADDI, 4'd14, 8'h01));
        end
        halt_here();
    endtask

    task automatic check_alu(input string tag);
        logic [15:0] a = 16'h1234;
        logic [15:0] b = 16'hF00F;
        chk({tag, " R3 add"}, mem[8'h80], a + b);
        chk({tag, " R3 sub"}, mem[8'h81], a - b);
        chk({tag, " R3 xor"}, mem[8'h82], a ^ b);
        chk({tag, " R3 and"}, mem[8'h83], a & b);
        chk({tag, " R3 or"},  mem[8'h84], a | b);
    endtask

    task automatic t_alu();
        prep(0);
        alu_program();
        run();
        check_alu("nowait");
    endtask

    task automatic t_imm();
        prep(1);
        put(enc(K_ADDI, 4'd14, 8'h80));
        put(enc(K_ADDI, 4'd1, 8'hFF));
        put(enc(K_LDHI, 4'd1, 8'hAB));
        put(enc(K_SW, 4'd1, 8'hE0));
        put(enc(K_ADDI, 4'd14, 8'h01));
        put(enc(K_LDHI, 4'd2, 8'hFF));
        put(enc(K_ADDI, 4'd2, 8'hFF));
        put(enc(K_ADDI, 4'd2, 8'h02));
        put(enc(K_SW, 4'd2, 8'hE0));
        put(enc(K_ADDI, 4'd14, 8'h01));
        put(enc(K_ADDI, 4'd3, 8'h80));
        put(enc(K_SW, 4'd3, 8'hE0));
        put(enc(K_ADDI, 4'd14, 8'h01));
        put(enc(K_ADDI, 4'd0, 8'h55));
        put(enc(K_ADDI, 4'd0, 8'h01));
        put(enc(K_SW, 4'd0, 8'hE0));
        halt_here();
        run();
        chk("R5 ldhi keeps low byte", mem[8'h80], 16'hABFF);
        chk("R4 addi wraps", mem[8'h81], 16'h0001);
        chk("R4 addi zero-extends", mem[8'h82], 16'h0080);
        chk("R11 r0 writable", mem[8'h83], 16'h0056);
    endtask

    task automatic t_shift();
        logic [15:0] v = 16'h8421;
        prep(0);
        put(enc(K_ADDI, 4'd14, 8'h80));
        put(enc(K_LDHI, 4'd1, 8'h84));
        put(enc(K_ADDI, 4'd1, 8'h21));
        put(enc(K_OR, 4'd2, 8'h11));  put(enc(K_SHL,  4'd2, 8'h4F));
        put(enc(K_OR, 4'd3, 8'h11));  put(enc(K_SHR,  4'd3, 8'h4A));
        put(enc(K_OR, 4'd4, 8'h11));  put(enc(K_SHRA, 4'd4, 8'h45));
        put(enc(K_OR, 4'd5, 8'h11));  put(enc(K_SHRA, 4'd5, 8'h0F));
        put(enc(K_OR, 4'd6, 8'h11));  put(enc(K_SHR,  4'd6, 8'hF0));
        put(enc(K_LDHI, 4'd7, 8'h40)); put(enc(K_SHRA, 4'd7, 8'h33));
        for (int k = 2; k <= 7; k++) begin
            put(enc(K_SW, 4'(k), 8'hE3));
            put(enc(K_ADDI, 4'd14, 8'h01));
        end
        halt_here();
        run();
        chk("R9 shl 4 (R2 low nibble ignored)", mem[8'h80], v << 4);
        chk("R9 shr 4", mem[8'h81], v >> 4);
        chk("R9 shra 4 negative", mem[8'h82], 16'($signed(v) >>> 4));
        chk("R9 shra 0", mem[8'h83], v);
        chk("R9 shr 15", mem[8'h84], 16'h0001);
        chk("R9 shra positive", mem[8'h85], 16'h0800);
    endtask

    task automatic t_mem();
        prep(2);
        img[8'h90] = 16'hBEEF;
        put(enc(K_ADDI, 4'd14, 8'h92));
        put(enc(K_ADDI, 4'd1, 8'h90));
        put(enc(K_LW, 4'd2, 8'h1C));
        put(enc(K_ADDI, 4'd2, 8'h01));
        put(enc(K_SW, 4'd2, 8'h17));
        put(enc(K_ADDI, 4'd3, 8'h91));
        put(enc(K_SW, 4'd1, 8'h30));
        put(enc(K_LW, 4'd1, 8'h10));
        put(enc(K_SW, 4'd1, 8'hE0));
        halt_here();
        run();
        chk("R6 lw then sw to rs1 address", mem[8'h90], 16'hBEF0);
        chk("R6 sw stores rd", mem[8'h91], 16'h0090);
        chk("R6 lw rd==rs1 uses old address", mem[8'h92], 16'hBEF0);
    endtask

    task automatic t_branch();
        prep(1);
        put_at(0,  enc(K_ADDI, 4'd2, 8'h05));
        put_at(1,  enc(K_ADDI, 4'd14, 8'h80));
        put_at(2,  enc(K_BZ,  4'd1, 8'd5));
        put_at(3,  enc(K_ADDI, 4'd9, 8'h01));
        put_at(4,  enc(K_ADDI, 4'd9, 8'h01));
        put_at(5,  enc(K_BNZ, 4'd1, 8'd7));
        put_at(6,  enc(K_ADDI, 4'd8, 8'h01));
        put_at(7,  enc(K_BNZ, 4'd2, 8'd9));
        put_at(8,  enc(K_ADDI, 4'd9, 8'h01));
        put_at(9,  enc(K_BZ,  4'd2, 8'd11));
        put_at(10, enc(K_ADDI, 4'd8, 8'h02));
        put_at(11, enc(K_SW, 4'd8, 8'hE0));
        put_at(12, enc(K_ADDI, 4'd14, 8'h01));
        put_at(13, enc(K_SW, 4'd9, 8'hE0));
        put_at(14, enc(K_JAL, 4'd13, 8'd14));
        run();
        chk("R7 fall-through paths taken", mem[8'h80], 16'h0003);
        chk("R7 taken branches skip code", mem[8'h81], 16'h0000);
    endtask

    task automatic t_jump();
        prep(0);
        put_at(0,    enc(K_ADDI, 4'd14, 8'h80));
        put_at(1,    enc(K_JAL, 4'd5, 8'h40));
        put_at(2,    enc(K_SW, 4'd5, 8'hE0));
        put_at(3,    enc(K_ADDI, 4'd14, 8'h01));
        put_at(4,    enc(K_SW, 4'd7, 8'hE0));
        put_at(5,    enc(K_ADDI, 4'd14, 8'h01));
        put_at(6,    enc(K_SW, 4'd9, 8'hE0));
        put_at(7,    enc(K_JAL, 4'd12, 8'hC8));
        put_at(8'h40, enc(K_ADDI, 4'd6, 8'h44));
        put_at(8'h41, enc(K_JALR, 4'd7, 8'h69));
        put_at(8'h42, enc(K_ADDI, 4'd9, 8'h01));
        put_at(8'h43, enc(K_ADDI, 4'd9, 8'h01));
        put_at(8'h44, enc(K_JALR, 4'd5, 8'h5F));
        put_at(8'hC8, enc(K_ADDI, 4'd14, 8'h01));
        put_at(8'hC9, enc(K_SW, 4'd12, 8'hE0));
        put_at(8'hCA, enc(K_JAL, 4'd13, 8'hCA));
        run();
        chk("R8 jalr rd==rs1 link", mem[8'h80], 16'h0045);
        chk("R8 jalr link", mem[8'h81], 16'h0042);
        chk("R8 jalr skips", mem[8'h82], 16'h0000);
        chk("R8 jal to high imm8 link", mem[8'h83], 16'h0008);
        chk("R7 targets zero-extended", 16'(oor_hits), 16'h0000);
    endtask

    task automatic t_stall();
        prep(3);
        alu_program();
        run();
        check_alu("wait3");
        chk("R10 outputs held while stalled", 16'(hold_errs), 16'h0000);
    endtask

    initial begin
        t_reset();
        t_alu();
        t_imm();
        t_shift();
        t_mem();
        t_branch();
        t_jump();
        t_stall();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule